// File: doc/BRIEF.md
# Four-Source Prioritized Interrupt Controller

This block gathers interrupt requests from four sources: a general external edge pin, a periodic timer pulse, a vertical-sync edge pin and a serial-interface event. Each request is latched in its own request flag. A per-source permission flag and a global enable flip-flop both gate the latched request. A fixed-priority picker chooses one winner. The controller tells the CPU side that an interrupt is pending. When the CPU pulses an accept strobe, the controller hands back a 2-bit vector index.

Each external pin has its own edge-select bit, which picks rising or falling edges. Writing that bit can itself raise a request when the new setting matches the current pin level. Software reaches every flag through a small register port. That port has a 2-bit selector, a write strobe, write data and combinational read data.

Global enable is controlled by three strobes: enable-set, enable-clear and return. An enable-set that arrives while a handler is in service is held back until the return strobe, so that the handler is not interrupted again before it finishes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all request, permission and edge-select flags read 0, the global enable and in-service state are 0, `irq_pend` is 0 and `vec_valid` is 0.
- R2: An external pin whose edge-select bit is 0 raises its request on a rising edge, and on a falling edge when the bit is 1. The flag reads 1 after the first clock edge that samples the new pin level. The general pin is source 0 and the vertical-sync pin is source 2.
- R3: Changing an edge-select bit from 0 to 1 while its pin is low, or from 1 to 0 while it is high, raises that pin's request one clock edge after the write takes effect. Changing it from 1 to 0 while low, or from 0 to 1 while high, leaves the flag unchanged.
- R4: The timer request (source 1) is raised by a high-to-low transition of `tmr_pulse`. A rising transition has no effect. The serial request (source 3) is raised on every clock edge that samples `ser_evt` high.
- R5: `irq_pend` equals the global enable ANDed with the OR of (request AND permission) over the four sources. It follows the flags in the same cycle.
- R6: When more than one permitted request is pending, the lowest source index wins: 0, then 1, then 2, then 3.
- R7: `accept` while `irq_pend` is 1 makes `vec_valid` 1 for exactly one cycle after the edge, with `vec_idx` set to the winner. It also clears the winner's request flag and the global enable, and sets the in-service state. `accept` while `irq_pend` is 0 is ignored.
- R8: Outside service, `en_set` sets the global enable on the next edge. `en_clr` clears it, and also cancels any held-back enable.
- R9: During service, `en_set` is held back. The next `reti` then sets the global enable and ends service. A `reti` with no held-back or concurrent `en_set` ends service and leaves the enable at 0. `reti` together with `en_set` sets the enable.
- R10: A write to the request flags takes priority, for every bit, over a hardware request or an acceptance clear in the same cycle.
- R11: Register map by `reg_sel`: 0 holds the request flags and 1 holds the permission flags, with bit i belonging to source i. 2 holds the edge-select bits in bits 0 and 2; bits 1 and 3 read 0. 3 reads {0, 0, in-service, global enable}, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | General external request pin (source 0) |
| vsync_pin | input | 1 | Vertical-sync request pin (source 2) |
| tmr_pulse | input | 1 | Timer interval pulse, falling edge requests (source 1) |
| ser_evt | input | 1 | Serial-interface event, high requests (source 3) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector for read and write |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Selected register contents |
| en_set | input | 1 | Enable-interrupt strobe |
| en_clr | input | 1 | Disable-interrupt strobe |
| accept | input | 1 | CPU accepts the pending interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_pend | output | 1 | A permitted request is pending and enabled |
| vec_valid | output | 1 | One-cycle strobe carrying the accepted vector |
| vec_idx | output | 2 | Index of the accepted source |

## Verification
`irq_pend` and `reg_rdata` follow the flags within the same cycle. A pin edge, timer fall or serial event shows in the flag after one clock edge. An edge-select write changes the flag two edges after the write: one edge applies the write and the next detects the edge. `vec_valid` rises one edge after `accept`, together with the flag clear and the enable drop. The bench drives inputs just after each falling clock edge and updates its reference model on the rising edge. It compares every output at the following falling edge, and the directed reads are counted to those same latencies.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/10ps
package prio_irq_pkg;
  localparam int SRC_N = 4;
  localparam int VEC_W = $clog2(SRC_N);
  localparam int EXT_N = 2;
  localparam int TMR_SLOT = 1;
  localparam int SER_SLOT = 3;

  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_PERM = 2'd1,
    SEL_EDGE = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // source slot of external pin k (0 -> general pin, 1 -> vertical sync)
  function automatic int ext_slot(input int k);
    return 2 * k;
  endfunction

  // lowest-index set bit wins
  function automatic logic [VEC_W-1:0] first_set(input logic [SRC_N-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
`timescale 1ns/10ps
module irq_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic hit
);
  logic eff;
  logic prev_q;

  assign eff = pin ^ fall_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= eff;
  end

  assign hit = eff & ~prev_q;

  // R3
  sel_drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fall_sel) && !pin && $past(!pin)) |-> !hit);
endmodule

// File: rtl/irq_src_stage.sv
`timescale 1ns/10ps
module irq_src_stage
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_N-1:0] pins,
  input  logic [EXT_N-1:0] fall_sel,
  input  logic             tmr_pulse,
  input  logic             ser_evt,
  output logic [SRC_N-1:0] hit_v
);
  logic [EXT_N-1:0] ext_hit;
  logic             tmr_prev_q;

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    irq_pin_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pins[g]),
      .fall_sel (fall_sel[g]),
      .hit      (ext_hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_prev_q <= 1'b0;
    else        tmr_prev_q <= tmr_pulse;
  end

  always_comb begin
    hit_v = '0;
    for (int k = 0; k < EXT_N; k++) hit_v[ext_slot(k)] = ext_hit[k];
    hit_v[TMR_SLOT] = tmr_prev_q & ~tmr_pulse;
    hit_v[SER_SLOT] = ser_evt;
  end
endmodule

// File: rtl/irq_req_bank.sv
`timescale 1ns/10ps
module irq_req_bank
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_v,
  input  logic [SRC_N-1:0] clr_v,
  input  logic             wr_en,
  input  logic [SRC_N-1:0] wdata,
  output logic [SRC_N-1:0] req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= '0;
    else if (wr_en) req_q <= wdata;
    else            req_q <= (req_q | set_v) & ~clr_v;
  end

  // R10
  sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> req_q == $past(wdata));

  // R7
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_v && !wr_en) |=> (req_q & $past(clr_v)) == '0);
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/10ps
module irq_prio_pick
  import prio_irq_pkg::*;
(
  input  logic [SRC_N-1:0] req,
  input  logic [SRC_N-1:0] perm,
  input  logic             gie,
  output logic             pend,
  output logic [VEC_W-1:0] win
);
  logic [SRC_N-1:0] live;

  assign live = req & perm;
  assign pend = gie & (|live);
  assign win  = first_set(live);
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/10ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_pin,
  input  logic       vsync_pin,
  input  logic       tmr_pulse,
  input  logic       ser_evt,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       accept,
  input  logic       reti,
  output logic       irq_pend,
  output logic       vec_valid,
  output logic [1:0] vec_idx
);
  logic [SRC_N-1:0] hit_v, req_q, perm_q, clr_v;
  logic [EXT_N-1:0] edge_q;
  logic             gie_q, svc_q, defer_q;
  logic             req_wr, acc_fire;
  logic [VEC_W-1:0] win;
  logic             vv_q;
  logic [VEC_W-1:0] vec_q;

  irq_src_stage u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      ({vsync_pin, ext_pin}),
    .fall_sel  (edge_q),
    .tmr_pulse (tmr_pulse),
    .ser_evt   (ser_evt),
    .hit_v     (hit_v)
  );

  assign req_wr = reg_wr && (reg_sel == SEL_REQ);

  irq_req_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (hit_v),
    .clr_v (clr_v),
    .wr_en (req_wr),
    .wdata (reg_wdata),
    .req_q (req_q)
  );

  irq_prio_pick u_pick (
    .req  (req_q),
    .perm (perm_q),
    .gie  (gie_q),
    .pend (irq_pend),
    .win  (win)
  );

  assign acc_fire = accept & irq_pend;
  assign clr_v    = acc_fire ? (SRC_N'(1) << win) : '0;

  // permission and edge-select registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= '0;
      edge_q <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_PERM) perm_q <= reg_wdata;
      if (reg_sel == SEL_EDGE) begin
        for (int k = 0; k < EXT_N; k++) edge_q[k] <= reg_wdata[ext_slot(k)];
      end
    end
  end

  // global enable, in-service and held-back enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      svc_q   <= 1'b0;
      defer_q <= 1'b0;
    end else if (acc_fire) begin
      gie_q   <= 1'b0;
      svc_q   <= 1'b1;
      defer_q <= 1'b0;
    end else begin
      if (reti) svc_q <= 1'b0;
      if (en_clr) begin
        gie_q   <= 1'b0;
        defer_q <= 1'b0;
      end else if (en_set && svc_q && !reti) begin
        defer_q <= 1'b1;
      end else if (en_set || (reti && defer_q)) begin
        gie_q   <= 1'b1;
        defer_q <= 1'b0;
      end
    end
  end

  // vector strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q  <= 1'b0;
      vec_q <= '0;
    end else begin
      vv_q <= acc_fire;
      if (acc_fire) vec_q <= win;
    end
  end

  assign vec_valid = vv_q;
  assign vec_idx   = vec_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_REQ:  reg_rdata = req_q;
      SEL_PERM: reg_rdata = perm_q;
      SEL_EDGE: for (int k = 0; k < EXT_N; k++) reg_rdata[ext_slot(k)] = edge_q[k];
      default:  reg_rdata = {2'b00, svc_q, gie_q};
    endcase
  end

  // R5
  pend_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> gie_q);

  // R7
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (vec_valid && !gie_q && svc_q));

  // R8
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !acc_fire) |=> !gie_q);

  // R9
  bare_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !en_set && !en_clr && !acc_fire && !defer_q) |=> gie_q == $past(gie_q));

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> ((req_q & perm_q) & ((SRC_N'(1) << win) - SRC_N'(1))) == '0);
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/10ps
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_pin = 1'b0, vsync_pin = 1'b0, tmr_pulse = 1'b0, ser_evt = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [3:0] reg_wdata = 4'd0;
  logic en_set = 1'b0, en_clr = 1'b0, accept = 1'b0, reti = 1'b0;
  logic [3:0] reg_rdata;
  logic irq_pend, vec_valid;
  logic [1:0] vec_idx;

  int vecs = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .vsync_pin(vsync_pin),
    .tmr_pulse(tmr_pulse), .ser_evt(ser_evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_set(en_set), .en_clr(en_clr),
    .accept(accept), .reti(reti), .irq_pend(irq_pend), .vec_valid(vec_valid),
    .vec_idx(vec_idx)
  );

  // reference model state
  bit [3:0] m_req, m_perm, m_edge;
  bit m_gie, m_svc, m_def, m_vv, m_pa, m_pv, m_pt;
  int m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_perm = 0; m_edge = 0;
      m_gie = 0; m_svc = 0; m_def = 0; m_vv = 0; m_vec = 0;
      m_pa = 1; m_pv = 1; m_pt = 0;
    end else begin
      bit [3:0] hits;
      bit ea, ev, fire, g_n, s_n, d_n;
      int w;
      ea = ext_pin ^ m_edge[0];
      ev = vsync_pin ^ m_edge[2];
      hits = 0;
      if (ea && !m_pa) hits[0] = 1;
      if (!tmr_pulse && m_pt) hits[1] = 1;
      if (ev && !m_pv) hits[2] = 1;
      if (ser_evt) hits[3] = 1;
      m_pa = ea; m_pv = ev; m_pt = tmr_pulse;
      w = -1;
      for (int i = 0; i < 4; i++) if (w < 0 && m_req[i] && m_perm[i]) w = i;
      fire = accept && m_gie && (w >= 0);
      g_n = m_gie; s_n = m_svc; d_n = m_def;
      if (fire) begin
        g_n = 0; s_n = 1; d_n = 0;
      end else begin
        if (reti) s_n = 0;
        if (en_clr) begin g_n = 0; d_n = 0; end
        else if (en_set && m_svc && !reti) d_n = 1;
        else if (en_set || (reti && m_def)) begin g_n = 1; d_n = 0; end
      end
      m_vv = fire;
      if (fire) m_vec = w;
      if (reg_wr && reg_sel == 2'd0) m_req = reg_wdata;
      else begin
        m_req = m_req | hits;
        if (fire) m_req[w] = 0;
      end
      if (reg_wr && reg_sel == 2'd1) m_perm = reg_wdata;
      if (reg_wr && reg_sel == 2'd2) m_edge = reg_wdata & 4'b0101;
      m_gie = g_n; m_svc = s_n; m_def = d_n;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] e;
      case (reg_sel)
        2'd0: e = m_req;
        2'd1: e = m_perm;
        2'd2: e = m_edge;
        default: e = {2'b00, m_svc, m_gie};
      endcase
      chk({4'd0, reg_rdata}, {4'd0, e}, "R11 model rdata");
      chk({7'd0, irq_pend}, {7'd0, m_gie && |(m_req & m_perm)}, "R5 model pend");
      chk({7'd0, vec_valid}, {7'd0, m_vv}, "R7 model vec_valid");
      if (m_vv) chk({6'd0, vec_idx}, 8'(m_vec), "R6 model vec_idx");
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic expect_rd(input logic [1:0] s, input logic [3:0] d, input string tag);
    reg_sel = s;
    #0.1;
    chk({4'd0, reg_rdata}, {4'd0, d}, tag);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    expect_rd(0, 4'h0, "R1 req after reset");
    expect_rd(1, 4'h0, "R1 perm after reset");
    expect_rd(2, 4'h0, "R1 edge after reset");
    chk({7'd0, irq_pend}, 8'd0, "R1 pend after reset");
    chk({7'd0, vec_valid}, 8'd0, "R1 vec_valid after reset");
    expect_rd(3, 4'h0, "R1 ctrl after reset");

    wr(1, 4'hF);
    en_set = 1; tick(); en_set = 0;
    expect_rd(3, 4'b0001, "R8 en_set sets enable");

    ext_pin = 1; tick();
    expect_rd(0, 4'b0001, "R2 rising edge on general pin");
    chk({7'd0, irq_pend}, 8'd1, "R5 pend with permitted request");

    accept = 1; tick(); accept = 0;
    chk({7'd0, vec_valid}, 8'd1, "R7 vec_valid after accept");
    chk({6'd0, vec_idx}, 8'd0, "R7 vec_idx general pin");
    expect_rd(0, 4'b0000, "R7 winner flag cleared");
    expect_rd(3, 4'b0010, "R7 in service, enable cleared");
    tick();
    chk({7'd0, vec_valid}, 8'd0, "R7 vec_valid one cycle");

    en_set = 1; tick(); en_set = 0;
    expect_rd(3, 4'b0010, "R9 en_set held back in service");
    reti = 1; tick(); reti = 0;
    expect_rd(3, 4'b0001, "R9 reti applies held enable");

    // R2 falling edge, R3 0->1 while high gives nothing
    wr(2, 4'b0001);
    tick();
    expect_rd(0, 4'b0000, "R3 select 0->1 with pin high no request");
    expect_rd(2, 4'b0001, "R11 edge readback");
    ext_pin = 0; tick();
    expect_rd(0, 4'b0001, "R2 falling edge selected");
    wr(0, 4'b0000);

    wr(2, 4'b0101);
    tick();
    expect_rd(0, 4'b0100, "R3 select 0->1 with vsync low requests");
    wr(2, 4'b0100);
    tick();
    expect_rd(0, 4'b0100, "R3 select 1->0 with pin low unchanged");

    tmr_pulse = 1; tick();
    expect_rd(0, 4'b0100, "R4 timer rise ignored");
    tmr_pulse = 0; tick();
    expect_rd(0, 4'b0110, "R4 timer fall requests");
    ser_evt = 1; tick(); ser_evt = 0;
    expect_rd(0, 4'b1110, "R4 serial event requests");

    accept = 1; tick(); accept = 0;
    chk({6'd0, vec_idx}, 8'd1, "R6 timer before vsync and serial");
    en_set = 1; reti = 1; tick(); en_set = 0; reti = 0;
    expect_rd(3, 4'b0001, "R9 reti with en_set enables");
    accept = 1; tick(); accept = 0;
    chk({6'd0, vec_idx}, 8'd2, "R6 vsync before serial");
    en_set = 1; reti = 1; tick(); en_set = 0; reti = 0;
    accept = 1; tick(); accept = 0;
    chk({6'd0, vec_idx}, 8'd3, "R6 serial last");
    en_set = 1; reti = 1; tick(); en_set = 0; reti = 0;

    wr(0, 4'b0010);
    wr(1, 4'b1101);
    chk({7'd0, irq_pend}, 8'd0, "R5 masked request not pending");
    wr(1, 4'hF);
    chk({7'd0, irq_pend}, 8'd1, "R5 unmasked request pending");

    ser_evt = 1; wr(0, 4'b0000); ser_evt = 0;
    expect_rd(0, 4'b0000, "R10 write beats serial set");
    wr(0, 4'b0010);
    accept = 1; wr(0, 4'b1000); accept = 0;
    expect_rd(0, 4'b1000, "R10 write beats accept clear");
    chk({6'd0, vec_idx}, 8'd1, "R7 accept with write still reports");

    wr(3, 4'hF);
    expect_rd(3, 4'b0010, "R11 ctrl write ignored");

    accept = 1; tick(); accept = 0;
    chk({7'd0, vec_valid}, 8'd0, "R7 accept without pend ignored");

    en_set = 1; tick(); en_set = 0;
    en_clr = 1; tick(); en_clr = 0;
    reti = 1; tick(); reti = 0;
    expect_rd(3, 4'b0000, "R9 en_clr cancels held enable");
    en_set = 1; tick(); en_set = 0;
    expect_rd(3, 4'b0001, "R8 en_set outside service");
    en_clr = 1; tick(); en_clr = 0;
    expect_rd(3, 4'b0000, "R8 en_clr clears enable");

    // mixed traffic checked by the model each cycle
    for (int n = 0; n < 200; n++) begin
      ext_pin = n[2]; vsync_pin = n[3] ^ n[0]; tmr_pulse = n[1];
      ser_evt = (n % 7) == 0;
      accept = (n % 5) == 1;
      en_set = (n % 6) == 2; reti = (n % 11) == 3;
      reg_wr = (n % 13) == 4; reg_sel = 2'(n % 4); reg_wdata = 4'(n * 3);
      tick();
    end
    {ext_pin, vsync_pin, tmr_pulse, ser_evt, accept, en_set, reti, reg_wr} = '0;
    repeat (3) tick();
    summary();
    $finish;
  end
endmodule